// File: doc/BRIEF.md
# Multiplexed Conversion-Result Output Formatter

This block sits between a 16-bit converter and a narrow 8-bit output bus. It takes one conversion result per pixel sample and sends it out in pieces over successive slots. One slot lasts half a converter-clock period, so the block is clocked at twice the converter rate. The slicing is chosen at run time from the format-select bits. A result can go out as two bytes with the upper byte first, as the upper byte alone, or as four nibbles, most significant first, on the upper half of the bus with the lower half held at zero.

The format in force is captured when a result starts. Later changes to the select bits therefore never split a word. A new result that arrives while a word is still being sent waits in a single pending register. If another result arrives before the current word finishes, the newer one replaces the waiting one. In the alternate output family, an extra latency of two converter clocks can be switched in. An active-low output enable releases the bus.

Top module: `ofm_out_formatter`

## Requirements
- R1: After reset, and until the first result is strobed in, the bus reads all zeros.
- R2: In the pair format, a result appears as its upper byte in the slot right after the strobe edge and its lower byte in the following slot. The pair format is used when the family bit is 0 with the single bit 0, or when the family bit is 1 with the single bit 1, or when the family bit is 1 with the three-channel bit 1.
- R3: With the family bit 0 and the single bit 1, each result takes exactly one slot, holding its upper byte (bits 15..8).
- R4: With the family bit 1, the single bit 0 and the three-channel bit 0, each result takes four slots. The slots carry bits 15..12, 11..8, 7..4 and 3..0 in that order on bus lines 7..4, with lines 3..0 at zero.
- R5: A result strobed on the edge that ends the last slot of the current word is output from the next slot with no gap.
- R6: Results strobed while a word is in progress do not disturb it. Only the most recent of them is output after the current word ends.
- R7: The format of a word is taken from the select bits on the edge that loads it. A select change during the word does not alter its remaining slots.
- R8: With the family bit 1 and the extra-latency bit 1, the whole slot sequence is delayed by four slots (two converter clocks). With the family bit 0, the extra-latency bit has no effect.
- R9: While the active-low output enable is high, the bus reads zero and the drive-enable output is low. While it is low, the drive-enable output is high.
- R10: Once the last slot of a word has been output with no result waiting, the bus returns to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, twice the converter clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_i | input | 16 | Conversion result |
| word_valid_i | input | 1 | Strobe for word_i, one cycle per result |
| fam_sel_i | input | 1 | Output family: 0 primary, 1 alternate |
| single_i | input | 1 | Primary family: upper byte only. Alternate family: pair format |
| tri_ch_i | input | 1 | Three-channel operation; in the alternate family it forces the pair format |
| extra_lat_i | input | 1 | Adds two converter clocks of latency (alternate family only) |
| oe_n_i | input | 1 | Active-low output enable |
| bus_o | output | 8 | Output data bus |
| bus_en_o | output | 1 | Drive enable for the bus pads |

## Verification
The bench builds the block with its default parameters: a 16-bit result, an 8-bit bus, two slots per converter clock and two converter clocks of extra latency. This gives a four-stage delay chain and a four-entry nibble selector. With these values the bench can compare the delayed bus against the undelayed slice stream four slots earlier, and can place strobes on each of the four nibble slots to test the replace-at-boundary and gap-free hand-over cases.

// File: rtl/ofm_pkg.sv
package ofm_pkg;

   typedef enum logic [1:0] {
      FMT_PAIR = 2'd0,
      FMT_HIGH = 2'd1,
      FMT_QUAD = 2'd2
   } fmt_e;

   // format chosen from the select bits
   function automatic fmt_e pick_fmt(input logic fam, input logic single, input logic tri_ch);
      if (!fam)
         return single ? FMT_HIGH : FMT_PAIR;
      else if (single || tri_ch)
         return FMT_PAIR;
      else
         return FMT_QUAD;
   endfunction

   // index of the final slot of a word in each format
   function automatic logic [1:0] last_slot(input fmt_e f);
      case (f)
         FMT_PAIR: return 2'd1;
         FMT_HIGH: return 2'd0;
         FMT_QUAD: return 2'd3;
         default:  return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/ofm_slot_seq.sv
module ofm_slot_seq
   import ofm_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int IDX_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              valid_i,
   input  fmt_e              fmt_i,
   output logic [WORD_W-1:0] cur_word_o,
   output fmt_e              cur_fmt_o,
   output logic [IDX_W-1:0]  slot_o,
   output logic              busy_o
);

   logic [WORD_W-1:0] pend_word_q;
   logic              pend_vld_q;
   logic [WORD_W-1:0] cur_word_q;
   fmt_e              cur_fmt_q;
   logic [IDX_W-1:0]  slot_q;
   logic              busy_q;
   logic              at_boundary;

   assign at_boundary = !busy_q || (slot_q == IDX_W'(last_slot(cur_fmt_q)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_word_q <= '0;
         pend_vld_q  <= 1'b0;
         cur_word_q  <= '0;
         cur_fmt_q   <= FMT_PAIR;
         slot_q      <= '0;
         busy_q      <= 1'b0;
      end else if (at_boundary) begin
         slot_q     <= '0;
         pend_vld_q <= 1'b0;
         if (valid_i) begin
            cur_word_q <= word_i;
            cur_fmt_q  <= fmt_i;
            busy_q     <= 1'b1;
         end else if (pend_vld_q) begin
            cur_word_q <= pend_word_q;
            cur_fmt_q  <= fmt_i;
            busy_q     <= 1'b1;
         end else begin
            busy_q     <= 1'b0;
         end
      end else begin
         slot_q <= slot_q + 1'b1;
         if (valid_i) begin
            pend_word_q <= word_i;
            pend_vld_q  <= 1'b1;
         end
      end
   end

   assign cur_word_o = cur_word_q;
   assign cur_fmt_o  = cur_fmt_q;
   assign slot_o     = slot_q;
   assign busy_o     = busy_q;

endmodule

// File: rtl/ofm_slicer.sv
module ofm_slicer
   import ofm_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int BUS_W  = 8,
   parameter int IDX_W  = 2
) (
   input  logic [WORD_W-1:0] word_i,
   input  fmt_e              fmt_i,
   input  logic [IDX_W-1:0]  slot_i,
   input  logic              busy_i,
   output logic [BUS_W-1:0]  byte_o
);

   localparam int NIB_W = BUS_W / 2;
   localparam int NIB_N = WORD_W / NIB_W;

   logic [NIB_W-1:0] nibs [NIB_N];

   for (genvar g = 0; g < NIB_N; g++) begin : g_nib
      assign nibs[g] = word_i[WORD_W-1-g*NIB_W -: NIB_W];
   end

   always_comb begin
      byte_o = '0;
      if (busy_i) begin
         case (fmt_i)
            FMT_PAIR: byte_o = slot_i[0] ? word_i[BUS_W-1:0] : word_i[WORD_W-1 -: BUS_W];
            FMT_HIGH: byte_o = word_i[WORD_W-1 -: BUS_W];
            FMT_QUAD: byte_o = {nibs[slot_i], {NIB_W{1'b0}}};
            default:  byte_o = '0;
         endcase
      end
   end

endmodule

// File: rtl/ofm_delay.sv
module ofm_delay #(
   parameter int W     = 8,
   parameter int DEPTH = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_i,
   output logic [W-1:0] out_o
);

   if (DEPTH == 0) begin : g_pass
      assign out_o = in_i;
   end else begin : g_pipe
      logic [W-1:0] stg [DEPTH];
      for (genvar s = 0; s < DEPTH; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      stg[s] <= '0;
            else if (s == 0) stg[s] <= in_i;
            else             stg[s] <= stg[(s == 0) ? 0 : s-1];
         end
      end
      assign out_o = stg[DEPTH-1];
   end

endmodule

// File: rtl/ofm_out_formatter.sv
module ofm_out_formatter
   import ofm_pkg::*;
#(
   parameter int WORD_W         = 16,
   parameter int BUS_W          = 8,
   parameter int SLOTS_PER_ADC  = 2,
   parameter int EXTRA_ADC_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] word_i,
   input  logic              word_valid_i,
   input  logic              fam_sel_i,
   input  logic              single_i,
   input  logic              tri_ch_i,
   input  logic              extra_lat_i,
   input  logic              oe_n_i,
   output logic [BUS_W-1:0]  bus_o,
   output logic              bus_en_o
);

   localparam int NIB_W = BUS_W / 2;
   localparam int NIB_N = WORD_W / NIB_W;
   localparam int IDX_W = $clog2(NIB_N);
   localparam int DLY   = SLOTS_PER_ADC * EXTRA_ADC_CLKS;

   if (WORD_W != 2 * BUS_W) begin : g_bad_width
      $error("ofm_out_formatter: WORD_W must be twice BUS_W");
   end
   if (BUS_W % 2 != 0) begin : g_bad_bus
      $error("ofm_out_formatter: BUS_W must be even");
   end
   if (NIB_N != 4) begin : g_bad_nib
      $error("ofm_out_formatter: nibble format needs four slots per word");
   end

   fmt_e              fmt_now;
   logic [WORD_W-1:0] cur_word;
   fmt_e              cur_fmt;
   logic [IDX_W-1:0]  slot;
   logic              busy;
   logic [BUS_W-1:0]  slice_byte;
   logic [BUS_W-1:0]  late_byte;
   logic              use_late;

   assign fmt_now = pick_fmt(fam_sel_i, single_i, tri_ch_i);

   ofm_slot_seq #(
      .WORD_W (WORD_W),
      .IDX_W  (IDX_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_i     (word_i),
      .valid_i    (word_valid_i),
      .fmt_i      (fmt_now),
      .cur_word_o (cur_word),
      .cur_fmt_o  (cur_fmt),
      .slot_o     (slot),
      .busy_o     (busy)
   );

   ofm_slicer #(
      .WORD_W (WORD_W),
      .BUS_W  (BUS_W),
      .IDX_W  (IDX_W)
   ) u_slice (
      .word_i (cur_word),
      .fmt_i  (cur_fmt),
      .slot_i (slot),
      .busy_i (busy),
      .byte_o (slice_byte)
   );

   ofm_delay #(
      .W     (BUS_W),
      .DEPTH (DLY)
   ) u_dly (
      .clk   (clk),
      .rst_n (rst_n),
      .in_i  (slice_byte),
      .out_o (late_byte)
   );

   assign use_late = fam_sel_i & extra_lat_i;
   assign bus_o    = oe_n_i ? '0 : (use_late ? late_byte : slice_byte);
   assign bus_en_o = !oe_n_i;

endmodule

// File: rtl/ofm_out_formatter_chk.sv
module ofm_out_formatter_chk
   import ofm_pkg::*;
#(
   parameter int BUS_W = 8,
   parameter int IDX_W = 2,
   parameter int DLY   = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             oe_n_i,
   input logic [BUS_W-1:0] bus_o,
   input logic             bus_en_o,
   input fmt_e             cur_fmt,
   input logic [IDX_W-1:0] slot,
   input logic             busy,
   input logic [BUS_W-1:0] slice_byte,
   input logic             use_late
);

   localparam int NIB_W = BUS_W / 2;

   logic [2:0] age_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           age_q <= '0;
      else if (age_q != 3'd7) age_q <= age_q + 1'b1;
   end

   // R9
   oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n_i |-> (bus_o == '0 && !bus_en_o));

   // R3
   high_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_fmt == FMT_HIGH) |-> (slot == '0));

   // R7
   fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && slot != '0) |-> $stable(cur_fmt));

   // R4
   nib_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cur_fmt == FMT_QUAD) |-> (slice_byte[NIB_W-1:0] == '0));

   // R2
   slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && slot != IDX_W'(last_slot(cur_fmt))) |=>
         (busy && slot == IDX_W'($past(slot) + 1'b1)));

   if (DLY == 4) begin : g_lat
      // R8
      late_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (age_q >= 3'd5 && use_late && !oe_n_i) |-> (bus_o == $past(slice_byte, 4)));
   end

endmodule

bind ofm_out_formatter ofm_out_formatter_chk #(
   .BUS_W (BUS_W),
   .IDX_W (IDX_W),
   .DLY   (DLY)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .oe_n_i     (oe_n_i),
   .bus_o      (bus_o),
   .bus_en_o   (bus_en_o),
   .cur_fmt    (cur_fmt),
   .slot       (slot),
   .busy       (busy),
   .slice_byte (slice_byte),
   .use_late   (use_late)
);

// File: tb/ofm_out_formatter_test.sv
module ofm_out_formatter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] wd = '0;
   logic        wv = 1'b0;
   logic        fam = 1'b0;
   logic        sgl = 1'b0;
   logic        tch = 1'b0;
   logic        xl = 1'b0;
   logic        oe_n = 1'b0;
   logic [7:0]  bus;
   logic        en;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ofm_out_formatter uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .word_i       (wd),
      .word_valid_i (wv),
      .fam_sel_i    (fam),
      .single_i     (sgl),
      .tri_ch_i     (tch),
      .extra_lat_i  (xl),
      .oe_n_i       (oe_n),
      .bus_o        (bus),
      .bus_en_o     (en)
   );

   function automatic logic [7:0] hi(input logic [15:0] w);
      return w[15:8];
   endfunction
   function automatic logic [7:0] lo(input logic [15:0] w);
      return w[7:0];
   endfunction
   function automatic logic [7:0] nib(input logic [15:0] w, input int k);
      logic [15:0] s;
      s = w << (4 * k);
      return {s[15:12], 4'b0000};
   endfunction

   task automatic check(input string req, input logic [7:0] exp);
      n_chk++;
      if (bus !== exp) begin
         n_fail++;
         $display("FAIL %s: bus actual %h expected %h", req, bus, exp);
      end
   endtask

   task automatic check_en(input string req, input logic exp);
      n_chk++;
      if (en !== exp) begin
         n_fail++;
         $display("FAIL %s: drive enable actual %b expected %b", req, en, exp);
      end
   endtask

   task automatic drive(input logic v, input logic [15:0] w);
      @(negedge clk);
      wv = v;
      wd = w;
   endtask

   task automatic sample;
      @(posedge clk);
      #2;
   endtask

   task automatic step(input logic v, input logic [15:0] w);
      drive(v, w);
      sample();
   endtask

   task automatic set_mode(input logic f, input logic s, input logic t, input logic x);
      @(negedge clk);
      fam = f; sgl = s; tch = t; xl = x;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 16'h0000);
   endtask

   task automatic t_reset;
      check("R1 reset bus", 8'h00);
      check_en("R9 enable after reset", 1'b1);
      idle(2);
      check("R1 idle before first word", 8'h00);
   endtask

   task automatic t_pair(input logic f, input logic s, input logic t, input logic [15:0] w);
      set_mode(f, s, t, 1'b0);
      idle(2);
      step(1'b1, w);
      check("R2 upper byte first", hi(w));
      step(1'b0, 16'h0000);
      check("R2 lower byte second", lo(w));
      step(1'b0, 16'h0000);
      check("R10 idle after word", 8'h00);
   endtask

   task automatic t_high;
      set_mode(1'b0, 1'b1, 1'b0, 1'b0);
      idle(2);
      step(1'b1, 16'hA1B2);
      check("R3 single slot word 0", 8'hA1);
      step(1'b1, 16'hC3D4);
      check("R3 R5 single slot word 1", 8'hC3);
      step(1'b1, 16'hE5F6);
      check("R3 R5 single slot word 2", 8'hE5);
      step(1'b0, 16'h0000);
      check("R10 idle after single slots", 8'h00);
   endtask

   task automatic t_quad;
      logic [15:0] a = 16'h9C3E;
      logic [15:0] b = 16'h5AF1;
      set_mode(1'b1, 1'b0, 1'b0, 1'b0);
      idle(2);
      step(1'b1, a);
      check("R4 nibble 0", nib(a, 0));
      for (int k = 1; k < 4; k++) begin
         step(1'b0, 16'h0000);
         check("R4 nibble order", nib(a, k));
      end
      step(1'b1, b);
      check("R5 gap-free next word", nib(b, 0));
      for (int k = 1; k < 4; k++) begin
         step(1'b0, 16'h0000);
         check("R4 second word nibbles", nib(b, k));
      end
      step(1'b0, 16'h0000);
      check("R10 idle after nibbles", 8'h00);
   endtask

   task automatic t_replace;
      logic [15:0] a = 16'h1234;
      logic [15:0] b = 16'hBEEF;
      logic [15:0] c = 16'h7E81;
      set_mode(1'b1, 1'b0, 1'b0, 1'b0);
      idle(2);
      step(1'b1, a);
      check("R6 current word slot 0", nib(a, 0));
      step(1'b1, b);
      check("R6 current word slot 1", nib(a, 1));
      step(1'b1, c);
      check("R6 current word slot 2", nib(a, 2));
      step(1'b0, 16'h0000);
      check("R6 current word slot 3", nib(a, 3));
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 16'h0000);
         check("R6 latest pending word", nib(c, k));
      end
      step(1'b0, 16'h0000);
      check("R6 dropped word not sent", 8'h00);
   endtask

   task automatic t_fmt_hold;
      set_mode(1'b0, 1'b0, 1'b0, 1'b0);
      idle(2);
      step(1'b1, 16'h4D2B);
      check("R7 upper byte", 8'h4D);
      @(negedge clk);
      sgl = 1'b1;
      wv = 1'b0;
      sample();
      check("R7 lower byte kept after select change", 8'h2B);
      step(1'b1, 16'h66A9);
      check("R7 new word takes new format", 8'h66);
      step(1'b0, 16'h0000);
      check("R7 R10 single slot then idle", 8'h00);
   endtask

   task automatic t_latency;
      logic [15:0] a = 16'hD00D;
      set_mode(1'b1, 1'b1, 1'b0, 1'b1);
      idle(6);
      step(1'b1, a);
      check("R8 delayed slot 0 quiet", 8'h00);
      for (int k = 1; k < 4; k++) begin
         step(1'b0, 16'h0000);
         check("R8 delay window quiet", 8'h00);
      end
      step(1'b0, 16'h0000);
      check("R8 upper byte four slots late", hi(a));
      step(1'b0, 16'h0000);
      check("R8 lower byte four slots late", lo(a));
      step(1'b0, 16'h0000);
      check("R8 idle after delayed word", 8'h00);
      set_mode(1'b0, 1'b0, 1'b0, 1'b1);
      idle(6);
      step(1'b1, 16'h3C5A);
      check("R8 extra latency ignored in primary family", 8'h3C);
      step(1'b0, 16'h0000);
      check("R8 primary family lower byte", 8'h5A);
      set_mode(1'b0, 1'b0, 1'b0, 1'b0);
      idle(2);
   endtask

   task automatic t_oe;
      set_mode(1'b0, 1'b0, 1'b0, 1'b0);
      idle(2);
      @(negedge clk);
      oe_n = 1'b1;
      wv = 1'b1;
      wd = 16'hF00F;
      sample();
      check("R9 bus released", 8'h00);
      check_en("R9 drive enable low", 1'b0);
      @(negedge clk);
      oe_n = 1'b0;
      wv = 1'b0;
      sample();
      check("R9 bus back after enable", 8'h0F);
      check_en("R9 drive enable high", 1'b1);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      sample();
      t_reset();
      t_pair(1'b0, 1'b0, 1'b0, 16'hA55A);
      t_pair(1'b1, 1'b1, 1'b0, 16'h0FF0);
      t_pair(1'b1, 1'b0, 1'b1, 16'h8421);
      t_high();
      t_quad();
      t_replace();
      t_fmt_hold();
      t_latency();
      t_oe();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule